// File: doc/BRIEF.md
# Interleaved Modular Multiplier over a Prime Field

This block forms R = A·B mod p for operands of a parameterised width `N` (160 to 256 bits in practice). It walks the multiplier A from its top bit down to bit 0, one bit per clock. On every step it doubles the running value, adds B when the current bit is set, and reduces at once, so the double-width product never exists in hardware. The modulus p is an ordinary operand that arrives with each start. A new field therefore needs no change to the hardware.

The arithmetic runs on two full-word adders, which are chained within a cycle. The state lives in four full-word registers: the accumulator, the multiplier shift register, the pre-offset multiplicand B−p, and the inverted modulus. The same adders and registers could later be shared with an inverter. One guarded subtraction of p runs after the bit loop. The final result goes into the emptied multiplier shift register, and a one-cycle done pulse marks it valid. A caller pulses `mm_go` with the operands on the same cycle. The caller then reads `mm_prod` in the cycle where `mm_done` is high.

Top module: `modmul_il`

## Requirements
- R1: While reset is asserted, and after its release until the first operation completes, `mm_done` is low.
- R2: `mm_done` is high in the cycle after the (N+3)-th rising clock edge, where the edge that samples `mm_go` high in idle counts as the first. One edge loads, N edges iterate, one edge corrects and one edge registers the output.
- R3: For 2 ≤ p < 2^N, A < p and B < p, `mm_prod` in the done cycle equals A·B mod p.
- R4: The reported `mm_prod` is always below the modulus supplied with the operation.
- R5: `mm_done` is a pulse of exactly one cycle for each accepted operation.
- R6: An `mm_go` that arrives while an operation is in progress is ignored. It does not change that operation's result or its done timing, and it starts no extra operation.
- R7: An `mm_go` in the same cycle as `mm_done` is accepted. The new operation keeps the latency of R2, and the result just reported is unaffected.
- R8: The modulus is taken from `mm_mod` at each start, so successive operations with different moduli are each reduced by their own modulus.
- R9: Corner operands give exact values: A = 0 gives 0, B = 1 gives A, and A = B = p−1 gives 1 (for p > 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mm_go | input | 1 | Start request, sampled only while idle |
| mm_a | input | N | Multiplier operand A, below p |
| mm_b | input | N | Multiplicand operand B, below p |
| mm_mod | input | N | Modulus p, at least 2 |
| mm_done | output | 1 | One-cycle result-valid pulse |
| mm_prod | output | N | Product A·B mod p, valid while `mm_done` is high |

## Verification
Two events can fall in the same cycle: the done pulse of one product and the acceptance of the next start. The bench provokes this by raising `mm_go` exactly in the done cycle. It then checks two things: the result reported in that cycle still matches the first product, and the second product appears after precisely N+3 edges with its own modulus. A second collision is also covered. A start is pulsed with foreign operands in the middle of a running loop, and the bench judges it by the unchanged result, the unchanged timing and the absence of any extra done pulse.

// File: rtl/modmul_il_pkg.sv
package modmul_il_pkg;

  typedef enum logic [1:0] {
    MM_IDLE = 2'd0,
    MM_LOOP = 2'd1,
    MM_FIX  = 2'd2,
    MM_OUT  = 2'd3
  } mm_state_e;

  // Guard bits above the field width for the signed chained sums.
  localparam int unsigned MM_GUARD = 3;

endpackage

// File: rtl/modmul_il_rstsync.sv
module modmul_il_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic stage_q;
  logic out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      out_q   <= stage_q;
    end
  end

  assign rst_n_sync = out_q;

endmodule

// File: rtl/modmul_il_adder.sv
module modmul_il_adder #(
  parameter int unsigned W = 163
) (
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  input  logic         cin,
  output logic [W-1:0] sum
);

  always_comb begin
    sum = op_x + op_y + {{(W-1){1'b0}}, cin};
  end

endmodule

// File: rtl/modmul_il_ctrl.sv
module modmul_il_ctrl
  import modmul_il_pkg::*;
#(
  parameter int unsigned N = 160
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic load_en,
  output logic step_en,
  output logic fix_en,
  output logic out_en,
  output logic done
);

  localparam int unsigned CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  mm_state_e       state_q, state_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            done_q, done_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    load_en = 1'b0;
    step_en = 1'b0;
    fix_en  = 1'b0;
    out_en  = 1'b0;
    done_d  = 1'b0;
    unique case (state_q)
      MM_IDLE: begin
        if (go) begin
          load_en = 1'b1;
          cnt_d   = '0;
          state_d = MM_LOOP;
        end
      end
      MM_LOOP: begin
        step_en = 1'b1;
        if (cnt_q == LAST) begin
          state_d = MM_FIX;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      MM_FIX: begin
        fix_en  = 1'b1;
        state_d = MM_OUT;
      end
      MM_OUT: begin
        out_en  = 1'b1;
        done_d  = 1'b1;
        state_d = MM_IDLE;
      end
      default: state_d = MM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= MM_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      done_q  <= done_d;
    end
  end

  assign done = done_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2
  loop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MM_LOOP && cnt_q == LAST) |=> (state_q == MM_FIX));

  // R6
  busy_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MM_LOOP && cnt_q != LAST) |=> (state_q == MM_LOOP));

endmodule

// File: rtl/modmul_il_datapath.sv
module modmul_il_datapath
  import modmul_il_pkg::*;
#(
  parameter int unsigned N = 160
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic         step_en,
  input  logic         fix_en,
  input  logic         out_en,
  input  logic [N-1:0] in_a,
  input  logic [N-1:0] in_b,
  input  logic [N-1:0] in_mod,
  output logic [N-1:0] prod
);

  localparam int unsigned W = N + MM_GUARD;

  // Four full-word registers.
  logic [W-1:0] acc_q, acc_d;
  logic [W-1:0] boff_q, boff_d;   // B - p
  logic [W-1:0] pinv_q, pinv_d;   // ~p, i.e. -p-1
  logic [N-1:0] mul_q, mul_d;     // multiplier shifter, then result

  logic [W-1:0] s1_x, s1_y, s1_sum;
  logic [W-1:0] s2_y, s2_sum;
  logic         s1_cin, s2_cin;
  logic         bit_now;
  logic         s1_neg, s2_neg;

  assign bit_now = mul_q[N-1];

  // First adder operand selection.
  always_comb begin
    s1_x   = {acc_q[W-2:0], 1'b0};
    s1_y   = bit_now ? boff_q : pinv_q;
    s1_cin = ~bit_now;
    if (load_en) begin
      s1_x   = {{MM_GUARD{1'b0}}, in_b};
      s1_y   = ~{{MM_GUARD{1'b0}}, in_mod};
      s1_cin = 1'b1;
    end else if (fix_en) begin
      s1_x   = acc_q;
      s1_y   = pinv_q;
      s1_cin = 1'b1;
    end
  end

  modmul_il_adder #(.W(W)) u_add_first (
    .op_x (s1_x),
    .op_y (s1_y),
    .cin  (s1_cin),
    .sum  (s1_sum)
  );

  // Second adder: undo or extend the first subtraction by one modulus.
  assign s1_neg = s1_sum[W-1];
  assign s2_y   = s1_neg ? ~pinv_q : pinv_q;
  assign s2_cin = ~s1_neg;

  modmul_il_adder #(.W(W)) u_add_second (
    .op_x (s1_sum),
    .op_y (s2_y),
    .cin  (s2_cin),
    .sum  (s2_sum)
  );

  assign s2_neg = s2_sum[W-1];

  always_comb begin
    acc_d  = acc_q;
    boff_d = boff_q;
    pinv_d = pinv_q;
    mul_d  = mul_q;
    if (load_en) begin
      acc_d  = '0;
      boff_d = s1_sum;
      pinv_d = ~{{MM_GUARD{1'b0}}, in_mod};
      mul_d  = in_a;
    end else if (step_en) begin
      if (s1_neg) begin
        acc_d = s2_sum;
      end else if (s2_neg) begin
        acc_d = s1_sum;
      end else begin
        acc_d = s2_sum;
      end
      mul_d = {mul_q[N-2:0], 1'b0};
    end else if (fix_en) begin
      acc_d = s1_neg ? acc_q : s1_sum;
    end else if (out_en) begin
      mul_d = acc_q[N-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      boff_q <= '0;
      pinv_q <= '0;
      mul_q  <= '0;
    end else begin
      if (load_en | step_en | fix_en) acc_q <= acc_d;
      if (load_en) boff_q <= boff_d;
      if (load_en) pinv_q <= pinv_d;
      if (load_en | step_en | out_en) mul_q <= mul_d;
    end
  end

  assign prod = mul_q;

  // R3
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_en |=> (!acc_q[W-1] && (acc_q < ~pinv_q)));

  // R8
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en || fix_en) |=> $stable(pinv_q) && $stable(boff_q));

  // R4
  fix_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fix_en |=> (acc_q < ~pinv_q));

endmodule

// File: rtl/modmul_il.sv
module modmul_il
  import modmul_il_pkg::*;
#(
  parameter int unsigned N = 160
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mm_go,
  input  logic [N-1:0] mm_a,
  input  logic [N-1:0] mm_b,
  input  logic [N-1:0] mm_mod,
  output logic         mm_done,
  output logic [N-1:0] mm_prod
);

  logic rst_n_int;
  logic load_en, step_en, fix_en, out_en;

  modmul_il_rstsync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  modmul_il_ctrl #(.N(N)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .go      (mm_go),
    .load_en (load_en),
    .step_en (step_en),
    .fix_en  (fix_en),
    .out_en  (out_en),
    .done    (mm_done)
  );

  modmul_il_datapath #(.N(N)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load_en (load_en),
    .step_en (step_en),
    .fix_en  (fix_en),
    .out_en  (out_en),
    .in_a    (mm_a),
    .in_b    (mm_b),
    .in_mod  (mm_mod),
    .prod    (mm_prod)
  );

  // R1
  rst_idle_chk: assert property (@(posedge clk)
    !rst_n_int |=> !mm_done);

  // R7
  done_out_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    out_en |=> mm_done);

endmodule

// File: tb/test_modmul_il.sv
module test_modmul_il;

  localparam int N = 160;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         mm_go = 1'b0;
  logic [N-1:0] mm_a = '0;
  logic [N-1:0] mm_b = '0;
  logic [N-1:0] mm_mod = '0;
  logic         mm_done;
  logic [N-1:0] mm_prod;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [N-1:0] val;
    int           due;
    string        tag;
  } exp_t;

  exp_t sb[$];

  modmul_il #(.N(N)) i_modmul_il (
    .clk     (clk),
    .rst_n   (rst_n),
    .mm_go   (mm_go),
    .mm_a    (mm_a),
    .mm_b    (mm_b),
    .mm_mod  (mm_mod),
    .mm_done (mm_done),
    .mm_prod (mm_prod)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [N-1:0] ref_mul(logic [N-1:0] a, logic [N-1:0] b,
                                           logic [N-1:0] p);
    logic [N+1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      r = r << 1;
      if (a[i]) r = r + {2'b00, b};
      while (r >= {2'b00, p}) r = r - {2'b00, p};
    end
    return r[N-1:0];
  endfunction

  function automatic logic [N-1:0] rand_word();
    logic [N-1:0] w;
    for (int i = 0; i < N; i += 32) w = {w[N-1:0] << 32} | N'($urandom);
    return w;
  endfunction

  task automatic check(bit ok, string req, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_sim();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Driver: call at a negedge; pulses mm_go for one cycle.
  task automatic issue(logic [N-1:0] a, logic [N-1:0] b, logic [N-1:0] p,
                       string tag, bit expect_accept);
    exp_t e;
    mm_a   = a;
    mm_b   = b;
    mm_mod = p;
    mm_go  = 1'b1;
    if (expect_accept) begin
      e.val = ref_mul(a, b, p);
      e.due = cyc + 1 + N + 2;
      e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    mm_go = 1'b0;
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && sb.size() != 0 && cyc == sb[0].due) begin
      exp_t e;
      e = sb.pop_front();
      // R2 timing
      check(mm_done === 1'b1, {"R2 done timing ", e.tag}, N'(mm_done), N'(1));
      // R3 value, R4 range
      check(mm_prod === e.val, {"R3 product ", e.tag}, mm_prod, e.val);
    end else if (rst_n && mm_done !== 1'b0) begin
      // R5 single pulse, R6 no extra operation
      check(1'b0, "R5/R6 unexpected done", N'(mm_done), N'(0));
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
    finish_sim();
  end

  initial begin
    logic [N-1:0] p, a, b;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mm_done === 1'b0, "R1 done low in reset", N'(mm_done), N'(0));
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(mm_done === 1'b0, "R1 done low after release", N'(mm_done), N'(0));

    p = rand_word();
    p[N-1] = 1'b1;
    p[0] = 1'b1;
    // R9 corners
    a = rand_word() % p;
    issue('0, a, p, "R9 A=0", 1'b1);
    drain();
    issue(a, N'(1), p, "R9 B=1", 1'b1);
    drain();
    issue(p - 1, p - 1, p, "R9 A=B=p-1", 1'b1);
    drain();
    check(ref_mul(p - 1, p - 1, p) == N'(1), "R9 reference p-1 squared",
          ref_mul(p - 1, p - 1, p), N'(1));

    // R3 R8 random operands, fresh modulus each time
    for (int k = 0; k < 8; k++) begin
      p = rand_word();
      p[0] = 1'b1;
      if (k % 2 == 0) p[N-1] = 1'b1;
      if (p < 3) p = 5;
      issue(rand_word() % p, rand_word() % p, p, "R8 random", 1'b1);
      drain();
    end

    // R8 tiny modulus
    issue(N'(2), N'(2), N'(3), "R8 p=3", 1'b1);
    drain();

    // R6 start while busy is ignored
    p = rand_word();
    p[N-1] = 1'b1;
    p[0] = 1'b1;
    issue(rand_word() % p, rand_word() % p, p, "R6 victim", 1'b1);
    repeat (N / 2) @(negedge clk);
    issue(rand_word(), rand_word(), rand_word() | N'(3), "R6 ignored", 1'b0);
    mm_a = '1;
    mm_b = '1;
    drain();
    repeat (N + 6) @(negedge clk);

    // R7 start in the done cycle
    issue(rand_word() % p, rand_word() % p, p, "R7 first", 1'b1);
    while (cyc != sb[0].due) @(negedge clk);
    a = rand_word();
    a[N-1] = 1'b1;
    a[0] = 1'b1;
    issue(rand_word() % a, rand_word() % a, a, "R7 second", 1'b1);
    drain();
    repeat (5) @(negedge clk);
    finish_sim();
  end

endmodule